// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Dispatcher

This block sits after warp selection in a streaming multiprocessor pipeline. Once per clock it looks at the head of the chosen warp's instruction buffer and decides which of the first one or two instructions can issue this cycle. Each instruction is sent to one of five execution pipe classes: single-precision (SP), special-function (SFU), tensor (TEN), double-precision (DP) and integer (INT). The block asserts one registered strobe per slot and pipe class, plus a pop per issued slot so that the buffer can retire the consumed entries.

A pipe class is eligible only when at least one unit of that class is configured and its output stage still has room. Issue is strictly in order: the second slot is considered only when the first slot issued. An optional different-units mode stops two instructions from the same warp from landing on the same execution class in one cycle. When the warp is parked at a barrier, or its buffer is empty, nothing issues and a separate diagnostic flag names each reason. The decision is made from the inputs sampled at a rising edge and appears on the outputs one cycle later.

Pipe index encoding used on all per-pipe buses: SP=0, SFU=1, TEN=2, DP=3, INT=4. Strobe bit `s*5+p` is slot `s`, pipe `p`.

Top module: `warp_dispatch`

## Requirements
- R1: While rst_n is low, every issue strobe, every pop and both diagnostic flags are 0.
- R2: If warp_waiting is high at a rising edge, the following cycle shows no strobe and no pop, and diag_barrier is 1.
- R3: If ibuf_valid[0] is low at a rising edge, the following cycle shows no strobe and no pop, and diag_empty is 1. Both diagnostic flags may be 1 together.
- R4: Op code 1 may go only to SFU (pipe 1), code 2 only to TEN (pipe 2), code 3 only to DP (pipe 3). Every other code (0, 4 to 7) is generic: it goes to SP (pipe 0) when SP is eligible, otherwise to INT (pipe 4), otherwise it does not issue.
- R5: Pipe p is eligible for slot 0 only when its unit count field is nonzero and its room field is nonzero. For slot 1 its room must exceed the number of slot-0 instructions already sent to it.
- R6: Slot 1 issues only if slot 0 issued in the same cycle and ibuf_valid[1] is high. A failed slot 0 ends the cycle's issue.
- R7: With diff_units_mode high, slot 1 may not go to the pipe that slot 0 used this cycle, including tensor after tensor. A generic op then falls back from SP to INT.
- R8: ibuf_pop[s] is 1 exactly when slot s issued, and each slot raises at most one strobe.
- R9: With MAX_ISSUE set to 1, only slot 0 exists and the result equals slot 0 of the dual-issue configuration, whatever diff_units_mode is.
- R10: The record of the last issued class does not survive across cycles. Slot 0 is never blocked by the different-units rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_waiting | input | 1 | Warp is held at a barrier |
| ibuf_valid | input | MAX_ISSUE | Head entries of the instruction buffer are valid |
| ibuf_op | input | MAX_ISSUE*3 | Op class code per head entry, slot s at [3s+:3] |
| unit_cnt | input | 5*UNIT_W | Configured unit count per pipe class |
| pipe_room | input | 5*ROOM_W | Free-slot count per pipe output stage |
| diff_units_mode | input | 1 | Forbid same class twice in one cycle |
| issue_strobe | output | MAX_ISSUE*5 | Registered issue strobes, slot s pipe p at bit 5s+p |
| ibuf_pop | output | MAX_ISSUE | Registered pop per issued slot |
| diag_empty | output | 1 | Previous cycle stalled on an empty buffer |
| diag_barrier | output | 1 | Previous cycle stalled on a barrier |

## Verification
The bench sweeps every pair of op codes against every mix of room levels (0, 1, 2 per pipe), against every pattern of unconfigured classes, and across both modes. The result is compared with an arithmetic model. The sweep targets these faults: a slot-1 issue after a failed slot 0, which would issue out of order; a room check that does not account for slot 0, which would double-book a pipe that has a single free entry; a different-units rule that skips tensor, which would let two tensor ops through; and a class tracker that carries over from the previous cycle, which would push slot 0 onto INT for no reason. A single-issue instance runs in parallel. If it leaked a second slot or applied the different-units rule, it would differ from slot 0 of the dual instance.

// File: rtl/wdisp_pkg.sv
package wdisp_pkg;

    localparam int NPIPE = 5;
    localparam int OP_W  = 3;

    typedef enum logic [2:0] {
        PIPE_SP   = 3'd0,
        PIPE_SFU  = 3'd1,
        PIPE_TEN  = 3'd2,
        PIPE_DP   = 3'd3,
        PIPE_INT  = 3'd4,
        PIPE_NONE = 3'd7
    } pipe_e;

    localparam logic [OP_W-1:0] OPC_SFU = 3'd1;
    localparam logic [OP_W-1:0] OPC_TEN = 3'd2;
    localparam logic [OP_W-1:0] OPC_DP  = 3'd3;

    function automatic logic [NPIPE-1:0] pipe_onehot(input pipe_e p);
        logic [NPIPE-1:0] v;
        v = '0;
        for (int i = 0; i < NPIPE; i++) begin
            if (p == pipe_e'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/wdisp_avail.sv
module wdisp_avail
    import wdisp_pkg::*;
#(
    parameter int UNIT_W = 4,
    parameter int ROOM_W = 2
) (
    input  logic [NPIPE*UNIT_W-1:0] unit_cnt,
    input  logic [NPIPE*ROOM_W-1:0] pipe_room,
    input  logic [NPIPE-1:0]        used,
    output logic [NPIPE-1:0]        avail
);
    genvar p;
    generate
        for (p = 0; p < NPIPE; p++) begin : g_pipe
            logic              has_unit;
            logic [ROOM_W-1:0] room;
            assign has_unit = |unit_cnt[p*UNIT_W +: UNIT_W];
            assign room     = pipe_room[p*ROOM_W +: ROOM_W];
            assign avail[p] = has_unit && (room > ROOM_W'(used[p]));
        end
    endgenerate
endmodule

// File: rtl/wdisp_route.sv
module wdisp_route
    import wdisp_pkg::*;
(
    input  logic            enable,
    input  logic [OP_W-1:0] op,
    input  logic [NPIPE-1:0] avail,
    input  pipe_e           prev,
    output pipe_e           sel,
    output logic            issued
);
    logic [NPIPE-1:0] ok;

    always_comb begin
        for (int i = 0; i < NPIPE; i++) begin
            ok[i] = avail[i] && (prev != pipe_e'(i));
        end
    end

    always_comb begin
        sel = PIPE_NONE;
        if (enable) begin
            unique case (op)
                OPC_SFU: if (ok[PIPE_SFU]) sel = PIPE_SFU;
                OPC_TEN: if (ok[PIPE_TEN]) sel = PIPE_TEN;
                OPC_DP:  if (ok[PIPE_DP])  sel = PIPE_DP;
                default: begin
                    if (ok[PIPE_SP])       sel = PIPE_SP;
                    else if (ok[PIPE_INT]) sel = PIPE_INT;
                end
            endcase
        end
        issued = (sel != PIPE_NONE);
    end
endmodule

// File: rtl/warp_dispatch.sv
module warp_dispatch
    import wdisp_pkg::*;
#(
    parameter int MAX_ISSUE = 2,
    parameter int UNIT_W    = 4,
    parameter int ROOM_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        warp_waiting,
    input  logic [MAX_ISSUE-1:0]        ibuf_valid,
    input  logic [MAX_ISSUE*OP_W-1:0]   ibuf_op,
    input  logic [NPIPE*UNIT_W-1:0]     unit_cnt,
    input  logic [NPIPE*ROOM_W-1:0]     pipe_room,
    input  logic                        diff_units_mode,
    output logic [MAX_ISSUE*NPIPE-1:0]  issue_strobe,
    output logic [MAX_ISSUE-1:0]        ibuf_pop,
    output logic                        diag_empty,
    output logic                        diag_barrier
);
    localparam int SW = MAX_ISSUE * NPIPE;

    pipe_e            sel   [MAX_ISSUE];
    pipe_e            prev  [MAX_ISSUE];
    logic [NPIPE-1:0] used  [MAX_ISSUE];
    logic [NPIPE-1:0] avail [MAX_ISSUE];
    logic [MAX_ISSUE-1:0] go;
    logic [MAX_ISSUE-1:0] iss;

    genvar s;
    generate
        for (s = 0; s < MAX_ISSUE; s++) begin : g_slot
            if (s == 0) begin : g_first
                assign used[s] = '0;
                assign prev[s] = PIPE_NONE;
                assign go[s]   = !warp_waiting && ibuf_valid[s];
            end else begin : g_next
                assign used[s] = used[s-1] | pipe_onehot(sel[s-1]);
                assign prev[s] = diff_units_mode ? sel[s-1] : PIPE_NONE;
                assign go[s]   = iss[s-1] && ibuf_valid[s] && !warp_waiting;
            end

            wdisp_avail #(.UNIT_W(UNIT_W), .ROOM_W(ROOM_W)) u_avail (
                .unit_cnt (unit_cnt),
                .pipe_room(pipe_room),
                .used     (used[s]),
                .avail    (avail[s])
            );

            wdisp_route u_route (
                .enable(go[s]),
                .op    (ibuf_op[s*OP_W +: OP_W]),
                .avail (avail[s]),
                .prev  (prev[s]),
                .sel   (sel[s]),
                .issued(iss[s])
            );
        end
    endgenerate

    logic [SW-1:0] strobe_d;
    always_comb begin
        strobe_d = '0;
        for (int k = 0; k < MAX_ISSUE; k++) begin
            strobe_d[k*NPIPE +: NPIPE] = pipe_onehot(sel[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_strobe <= '0;
            ibuf_pop     <= '0;
            diag_empty   <= 1'b0;
            diag_barrier <= 1'b0;
        end else begin
            issue_strobe <= strobe_d;
            ibuf_pop     <= iss;
            diag_empty   <= !ibuf_valid[0];
            diag_barrier <= warp_waiting;
        end
    end

    // Assertions guarding the registered outputs
    assert_barrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warp_waiting |=> (issue_strobe == '0) && (ibuf_pop == '0) && diag_barrier);

    assert_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ibuf_valid[0] |=> (issue_strobe == '0) && (ibuf_pop == '0) && diag_empty);

    genvar a, q;
    generate
        for (a = 0; a < MAX_ISSUE; a++) begin : g_slot_chk
            assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ibuf_pop[a] == (|issue_strobe[a*NPIPE +: NPIPE]));
            assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(issue_strobe[a*NPIPE +: NPIPE]));
            if (a > 0) begin : g_chain
                assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    ibuf_pop[a] |-> ibuf_pop[a-1]);
                for (q = 0; q < NPIPE; q++) begin : g_diff
                    assert_diff_R7: assert property (@(posedge clk) disable iff (!rst_n)
                        diff_units_mode |=> !(issue_strobe[(a-1)*NPIPE+q] && issue_strobe[a*NPIPE+q]));
                end
            end
        end
        for (q = 0; q < NPIPE; q++) begin : g_pipe_chk
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < MAX_ISSUE; k++) hit = hit | issue_strobe[k*NPIPE+q];
            end
            assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (unit_cnt[q*UNIT_W +: UNIT_W] == '0) |=> !hit);
        end
    endgenerate
endmodule

// File: tb/test_warp_dispatch.sv
module test_warp_dispatch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        waiting, diff;
    logic [1:0]  valid;
    logic [2:0]  op0, op1;
    logic [19:0] units;
    logic [9:0]  room;
    logic [9:0]  strobe;
    logic [1:0]  pop;
    logic        d_empty, d_barrier;
    logic [4:0]  strobe1;
    logic        pop1;
    logic        d_empty1, d_barrier1;

    int total = 0;
    int bad = 0;

    warp_dispatch #(.MAX_ISSUE(2)) i_warp_dispatch (
        .clk(clk), .rst_n(rst_n), .warp_waiting(waiting), .ibuf_valid(valid),
        .ibuf_op({op1, op0}), .unit_cnt(units), .pipe_room(room),
        .diff_units_mode(diff), .issue_strobe(strobe), .ibuf_pop(pop),
        .diag_empty(d_empty), .diag_barrier(d_barrier));

    warp_dispatch #(.MAX_ISSUE(1)) i_warp_dispatch_single (
        .clk(clk), .rst_n(rst_n), .warp_waiting(waiting), .ibuf_valid(valid[0]),
        .ibuf_op(op0), .unit_cnt(units), .pipe_room(room),
        .diff_units_mode(diff), .issue_strobe(strobe1), .ibuf_pop(pop1),
        .diag_empty(d_empty1), .diag_barrier(d_barrier1));

    task automatic check(string tag, string ctx, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s (%s) got=%h exp=%h", tag, ctx, got, exp);
        end
    endtask

    // Model: pipe a slot may use, or -1
    function automatic int route_m(int op, logic [4:0] av, int prev);
        case (op)
            1: return (av[1] && prev != 1) ? 1 : -1;
            2: return (av[2] && prev != 2) ? 2 : -1;
            3: return (av[3] && prev != 3) ? 3 : -1;
            default: begin
                if (av[0] && prev != 0) return 0;
                if (av[4] && prev != 4) return 4;
                return -1;
            end
        endcase
    endfunction

    task automatic apply_and_check(string ctx);
        logic [4:0] av0, av1;
        int p0, p1;
        logic [9:0] es;
        logic [1:0] ep;
        for (int p = 0; p < 5; p++) begin
            av0[p] = (units[p*4 +: 4] != 0) && (room[p*2 +: 2] != 0);
        end
        p0 = -1; p1 = -1;
        if (!waiting && valid[0]) p0 = route_m(int'(op0), av0, -1);
        for (int p = 0; p < 5; p++) begin
            av1[p] = (units[p*4 +: 4] != 0) && (int'(room[p*2 +: 2]) > ((p == p0) ? 1 : 0));
        end
        if (p0 >= 0 && valid[1] && !waiting) p1 = route_m(int'(op1), av1, diff ? p0 : -1);
        es = '0; ep = '0;
        if (p0 >= 0) begin es[p0] = 1'b1; ep[0] = 1'b1; end
        if (p1 >= 0) begin es[5 + p1] = 1'b1; ep[1] = 1'b1; end
        @(posedge clk);
        #1;
        check("R4", ctx, 16'(strobe[4:0]), 16'(es[4:0]));
        check(diff ? "R7" : "R6", ctx, 16'(strobe[9:5]), 16'(es[9:5]));
        check("R8", ctx, 16'(pop), 16'(ep));
        check("R3", ctx, 16'(d_empty), 16'(!valid[0]));
        check("R2", ctx, 16'(d_barrier), 16'(waiting));
        check("R9", ctx, 16'({pop1, strobe1}), 16'({ep[0], es[4:0]}));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        waiting = 1'b0; diff = 1'b0; valid = 2'b11; op0 = 3'd0; op1 = 3'd0;
        units = {5{4'd1}}; room = {5{2'd2}};
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset", 16'({strobe, pop, d_empty, d_barrier}), 16'd0);
        check("R1", "reset single", 16'({strobe1, pop1, d_empty1, d_barrier1}), 16'd0);
        rst_n = 1'b1;

        // Directed: R10 tracker cleared each cycle
        diff = 1'b1; op0 = 3'd0; op1 = 3'd0;
        apply_and_check("R10 first");
        apply_and_check("R10 again");
        check("R10", "slot0 on SP after SP cycle", 16'(strobe), 16'b10000_00001);

        // Directed: tensor after tensor in diff mode
        op0 = 3'd2; op1 = 3'd2;
        apply_and_check("R7 tensor pair");
        check("R7", "tensor pair blocked", 16'(pop), 16'b01);
        diff = 1'b0;
        apply_and_check("R7 tensor pair off");

        // Directed: barrier plus empty together
        waiting = 1'b1; valid = 2'b00;
        apply_and_check("R2 R3 both");
        waiting = 1'b0; valid = 2'b11;

        // Status / validity sweep
        for (int w = 0; w < 2; w++) begin
            for (int v = 0; v < 4; v++) begin
                for (int o = 0; o < 8; o++) begin
                    waiting = w[0]; valid = v[1:0]; op0 = o[2:0]; op1 = 3'd0;
                    apply_and_check("status sweep");
                end
            end
        end
        waiting = 1'b0; valid = 2'b11;

        // R5 room sweep: each pipe room in {0,1,2}, all op pairs, both modes
        for (int r = 0; r < 243; r++) begin
            int t;
            t = r;
            for (int p = 0; p < 5; p++) begin
                room[p*2 +: 2] = 2'(t % 3);
                t = t / 3;
            end
            for (int m = 0; m < 2; m++) begin
                for (int o = 0; o < 64; o++) begin
                    diff = m[0]; op0 = 3'(o % 8); op1 = 3'(o / 8);
                    apply_and_check("R5 room sweep");
                end
            end
        end

        // R5 unit-count sweep: unconfigured classes never issue
        room = {5{2'd2}};
        for (int u = 0; u < 32; u++) begin
            for (int p = 0; p < 5; p++) units[p*4 +: 4] = u[p] ? 4'(p * 3 + 1) : 4'd0;
            for (int m = 0; m < 2; m++) begin
                for (int o = 0; o < 64; o++) begin
                    diff = m[0]; op0 = 3'(o % 8); op1 = 3'(o / 8);
                    apply_and_check("R5 unit sweep");
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule